// File: doc/BRIEF.md
# Protected-Mode Data and Stack Segment Load Checker

This block validates a 16-bit segment selector that is about to be loaded into a data segment register or the stack segment register. It rejects a null selector only for stack loads. For any other selector it uses one selector bit to choose between the local and the global descriptor table, and checks that the whole 8-byte descriptor lies inside the chosen table. It then reads the descriptor as two 32-bit words over a simple memory read port and applies the type, privilege and presence rules.

A load can end in one of two ways. It can end with a fault: a class and a 16-bit error code. Or it can end with the decoded segment base, byte-granular limit and attribute bits. When a successful descriptor has its accessed flag clear, the block sets the flag and writes the upper word back to memory before it reports completion.

The surrounding core pulses `start` while `busy` is low. The core waits for the single-cycle `done` strobe, and `fault_valid` qualifies that strobe as a fault. The memory returns read data one cycle after a read request.

Top module: `seg_load_checker`

## Requirements
- R1: A selector with bits 15:2 all zero is null. For a stack load it gives a GP fault with error code 0. For a data load it succeeds with `seg_null` set and with base, limit and attributes all zero. Either result is reported one cycle after `start`, and memory is not accessed.
- R2: Selector bit 2 set selects the local table, and clear selects the global table. The descriptor address is the table base plus the selector with its low 3 bits cleared. The low word is read at that address and the upper word at that address plus 4.
- R3: If (selector with its low 3 bits cleared) + 7 is greater than the chosen table limit, a GP fault is reported one cycle after `start`, and no memory access is made. Every fault's error code is the selector with bits 1:0 cleared.
- R4: The descriptor class flag is bit 12 of the upper word. If it is clear (a system descriptor), the load is a GP fault.
- R5: A stack load needs a data descriptor that is writable. Upper-word bit 11 (code) must be 0 and bit 9 (writable) must be 1. RPL (selector bits 1:0) and DPL (upper bits 14:13) must both equal CPL. Otherwise the load is a GP fault.
- R6: A data load of a code descriptor whose readable bit (bit 9) is clear is a GP fault.
- R7: A data load of anything other than conforming code (bit 11 set with bit 10 set) needs DPL >= CPL and DPL >= RPL. Otherwise it is a GP fault. Conforming readable code is exempt from this check.
- R8: If all the checks above pass but the present bit (bit 15) is clear, a stack load reports a stack fault and a data load reports a not-present fault. A GP fault from R4 to R7 takes priority over this.
- R9: On success with the accessed bit (bit 8) clear, exactly one write of the upper word with bit 8 set goes to the upper-word address. If the bit is already set, nothing is written.
- R10: On success, the outputs are decoded as follows.
  - Base is {upper[31:24], upper[7:0], low[31:16]}.
  - Raw limit is {upper[19:16], low[15:0]}. When bit 23 is set it becomes raw<<12 | 0xFFF.
  - Attributes are {upper[23:20], upper[15:9], 1}.
- R11: Fault class encoding is 1 = GP, 2 = stack fault, 3 = not-present. `fault_valid` is high only together with `done`. A fetched load completes 4 cycles after `start`, or 5 cycles when a write-back is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load check (accepted when not busy) |
| is_stack | input | 1 | 1 = stack segment load, 0 = data segment load |
| selector | input | 16 | Selector being loaded |
| cpl | input | 2 | Current privilege level |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | LIM_W | Global table limit |
| ldt_base | input | ADDR_W | Local table base address |
| ldt_limit | input | LIM_W | Local table limit |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion strobe |
| fault_valid | output | 1 | Qualifies `done` as a fault |
| fault_class | output | 2 | 1 GP, 2 stack, 3 not present |
| fault_code | output | 16 | Error code |
| seg_null | output | 1 | Null data selector loaded |
| seg_base | output | 32 | Decoded base |
| seg_limit | output | 32 | Decoded byte limit |
| seg_attr | output | 12 | Decoded attributes |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after request |

## Verification
Null and over-limit selectors are settled without memory, so `done` rises one cycle after `start` is sampled. A fetched descriptor takes four cycles: two reads, then evaluation as the upper word arrives. An accessed-bit write-back adds a fifth cycle. The bench model predicts that exact cycle for each load and compares `done` on every cycle from the first to the seventh after `start`, so both an early strobe and a late strobe are caught. Result fields are compared only in the predicted cycle. The write count and the stored upper word are inspected once the load has finished.

// File: rtl/segchk_pkg.sv
// Shared types and descriptor bit positions for the segment load checker.
// Assumes the upper descriptor word follows the usual protected-mode layout.
package segchk_pkg;
    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_GP   = 2'd1,
        FC_SS   = 2'd2,
        FC_NP   = 2'd3
    } fault_cls_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_EVAL,
        ST_WB
    } seg_state_t;

    localparam int A_BIT    = 8;
    localparam int RW_BIT   = 9;
    localparam int C_BIT    = 10;
    localparam int CODE_BIT = 11;
    localparam int S_BIT    = 12;
    localparam int DPL_LSB  = 13;
    localparam int P_BIT    = 15;
endpackage

// File: rtl/seg_sel_decode.sv
// Selector decode: null detection, table choice, descriptor address and
// table limit check. Purely combinational; assumes selector bits 1:0 are
// handled by the caller.
module seg_sel_decode #(
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 16
) (
    input  logic [15:2]       sel_hi,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [LIM_W-1:0]  gdt_limit,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic [LIM_W-1:0]  ldt_limit,
    output logic              is_null,
    output logic              over_limit,
    output logic [ADDR_W-1:0] desc_addr
);
    localparam int CW = ((LIM_W > 16) ? LIM_W : 16) + 1;

    logic [15:0]  offset;
    logic [CW-1:0] last_byte;
    logic [CW-1:0] lim_ext;

    // Derive table choice, byte offset and bounds test.
    always_comb begin
        offset     = {sel_hi[15:3], 3'b000};
        is_null    = (sel_hi == '0);
        last_byte  = CW'(offset) + CW'(7);
        lim_ext    = sel_hi[2] ? CW'(ldt_limit) : CW'(gdt_limit);
        over_limit = (last_byte > lim_ext);
        desc_addr  = (sel_hi[2] ? ldt_base : gdt_base) + ADDR_W'(offset);
    end
endmodule

// File: rtl/seg_rules.sv
// Type, privilege and presence rules for a fetched descriptor.
// Assumes the descriptor flags are already split out; GP outranks presence.
module seg_rules
    import segchk_pkg::*;
(
    input  logic       is_stack,
    input  logic [1:0] rpl,
    input  logic [1:0] cpl,
    input  logic [1:0] dpl,
    input  logic       f_s,
    input  logic       f_code,
    input  logic       f_conf,
    input  logic       f_rw,
    input  logic       f_present,
    output fault_cls_t cls
);
    // Pick the first failing rule, or none.
    always_comb begin
        cls = FC_NONE;
        if (!f_s) begin
            cls = FC_GP;
        end else if (is_stack) begin
            if (f_code || !f_rw || (rpl != cpl) || (dpl != cpl))
                cls = FC_GP;
        end else begin
            if (f_code && !f_rw)
                cls = FC_GP;
            else if (!(f_code && f_conf) && ((dpl < cpl) || (dpl < rpl)))
                cls = FC_GP;
        end
        if ((cls == FC_NONE) && !f_present)
            cls = is_stack ? FC_SS : FC_NP;
    end
endmodule

// File: rtl/seg_unpack.sv
// Extracts base, byte-granular limit and attribute bits from a descriptor.
// Assumes the accessed flag is reported as set (it is set on every success).
module seg_unpack (
    input  logic [31:0] lo,
    input  logic [31:9] hi_up,
    input  logic [7:0]  hi_lo,
    output logic [31:0] base,
    output logic [31:0] limit,
    output logic [11:0] attr
);
    logic [19:0] raw_lim;

    // Reassemble the scattered fields.
    always_comb begin
        raw_lim = {hi_up[19:16], lo[15:0]};
        base    = {hi_up[31:24], hi_lo, lo[31:16]};
        limit   = hi_up[23] ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};
        attr    = {hi_up[23:20], hi_up[15:9], 1'b1};
    end
endmodule

// File: rtl/seg_load_checker.sv
// Top of the segment load checker. Sequences decode, two descriptor reads,
// rule evaluation and an optional accessed-bit write-back.
// Assumes memory read data arrives one cycle after mem_rd_en and that start
// is only raised while busy is low.
module seg_load_checker
    import segchk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_stack,
    input  logic [15:0]       selector,
    input  logic [1:0]        cpl,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [LIM_W-1:0]  gdt_limit,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic [LIM_W-1:0]  ldt_limit,
    output logic              busy,
    output logic              done,
    output logic              fault_valid,
    output logic [1:0]        fault_class,
    output logic [15:0]       fault_code,
    output logic              seg_null,
    output logic [31:0]       seg_base,
    output logic [31:0]       seg_limit,
    output logic [11:0]       seg_attr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    seg_state_t        state;
    logic              stack_q;
    logic [15:0]       sel_q;
    logic [1:0]        cpl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       lo_q;
    logic [31:0]       hi_q;

    logic              dec_null;
    logic              dec_over;
    logic [ADDR_W-1:0] dec_addr;
    fault_cls_t        rule_cls;
    logic [31:0]       hi_view;
    logic [31:0]       up_base;
    logic [31:0]       up_limit;
    logic [11:0]       up_attr;

    seg_sel_decode #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_dec (
        .sel_hi     (selector[15:2]),
        .gdt_base   (gdt_base),
        .gdt_limit  (gdt_limit),
        .ldt_base   (ldt_base),
        .ldt_limit  (ldt_limit),
        .is_null    (dec_null),
        .over_limit (dec_over),
        .desc_addr  (dec_addr)
    );

    seg_rules u_rules (
        .is_stack  (stack_q),
        .rpl       (sel_q[1:0]),
        .cpl       (cpl_q),
        .dpl       (mem_rdata[DPL_LSB+1:DPL_LSB]),
        .f_s       (mem_rdata[S_BIT]),
        .f_code    (mem_rdata[CODE_BIT]),
        .f_conf    (mem_rdata[C_BIT]),
        .f_rw      (mem_rdata[RW_BIT]),
        .f_present (mem_rdata[P_BIT]),
        .cls       (rule_cls)
    );

    // Upper word comes straight from memory while evaluating, from the
    // holding register during write-back.
    assign hi_view = (state == ST_WB) ? hi_q : mem_rdata;

    seg_unpack u_unpack (
        .lo    (lo_q),
        .hi_up (hi_view[31:9]),
        .hi_lo (hi_view[7:0]),
        .base  (up_base),
        .limit (up_limit),
        .attr  (up_attr)
    );

    // Memory port driven from the current state.
    always_comb begin
        mem_rd_en = (state == ST_RD_LO) || (state == ST_RD_HI);
        mem_wr_en = (state == ST_WB);
        mem_addr  = (state == ST_RD_LO) ? addr_q : addr_q + ADDR_W'(4);
        mem_wdata = hi_q | (32'd1 << A_BIT);
    end

    assign busy = (state != ST_IDLE);

    // Sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            stack_q     <= 1'b0;
            sel_q       <= '0;
            cpl_q       <= '0;
            addr_q      <= '0;
            lo_q        <= '0;
            hi_q        <= '0;
            done        <= 1'b0;
            fault_valid <= 1'b0;
            fault_class <= FC_NONE;
            fault_code  <= '0;
            seg_null    <= 1'b0;
            seg_base    <= '0;
            seg_limit   <= '0;
            seg_attr    <= '0;
        end else begin
            done        <= 1'b0;
            fault_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        stack_q <= is_stack;
                        sel_q   <= selector;
                        cpl_q   <= cpl;
                        addr_q  <= dec_addr;
                        if (dec_null) begin
                            done       <= 1'b1;
                            fault_code <= '0;
                            if (is_stack) begin
                                fault_valid <= 1'b1;
                                fault_class <= FC_GP;
                                seg_null    <= 1'b0;
                            end else begin
                                fault_class <= FC_NONE;
                                seg_null    <= 1'b1;
                                seg_base    <= '0;
                                seg_limit   <= '0;
                                seg_attr    <= '0;
                            end
                        end else if (dec_over) begin
                            done        <= 1'b1;
                            fault_valid <= 1'b1;
                            fault_class <= FC_GP;
                            fault_code  <= {selector[15:2], 2'b00};
                            seg_null    <= 1'b0;
                        end else begin
                            state <= ST_RD_LO;
                        end
                    end
                end
                ST_RD_LO: state <= ST_RD_HI;
                ST_RD_HI: begin
                    lo_q  <= mem_rdata;
                    state <= ST_EVAL;
                end
                ST_EVAL: begin
                    hi_q     <= mem_rdata;
                    seg_null <= 1'b0;
                    if (rule_cls != FC_NONE) begin
                        done        <= 1'b1;
                        fault_valid <= 1'b1;
                        fault_class <= rule_cls;
                        fault_code  <= {sel_q[15:2], 2'b00};
                        state       <= ST_IDLE;
                    end else if (!mem_rdata[A_BIT]) begin
                        state <= ST_WB;
                    end else begin
                        done        <= 1'b1;
                        fault_class <= FC_NONE;
                        seg_base    <= up_base;
                        seg_limit   <= up_limit;
                        seg_attr    <= up_attr;
                        state       <= ST_IDLE;
                    end
                end
                ST_WB: begin
                    done        <= 1'b1;
                    fault_class <= FC_NONE;
                    seg_base    <= up_base;
                    seg_limit   <= up_limit;
                    seg_attr    <= up_attr;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seg_load_checker_chk.sv
// Port-level protocol checks for seg_load_checker, attached by bind.
// Assumes the same parameters as the checked instance.
module seg_load_checker_chk #(
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              is_stack,
    input logic [15:0]       selector,
    input logic [LIM_W-1:0]  gdt_limit,
    input logic [LIM_W-1:0]  ldt_limit,
    input logic              done,
    input logic              fault_valid,
    input logic [1:0]        fault_class,
    input logic [15:0]       fault_code,
    input logic              seg_null,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [31:0]       mem_wdata
);
    logic        take;
    logic        sel_zero;
    logic [31:0] tbl_lim;
    logic [31:0] top_byte;

    // Spec-level view of the accepted request.
    always_comb begin
        take     = start && !busy;
        sel_zero = (selector[15:2] == 14'd0);
        tbl_lim  = selector[2] ? 32'(ldt_limit) : 32'(gdt_limit);
        top_byte = {16'd0, selector[15:3], 3'b111};
    end

    AST_NULL_STACK_GP: assert property (@(posedge clk) disable iff (!rst_n)
        take && sel_zero && is_stack |=> done && fault_valid && fault_class == 2'd1 && fault_code == 16'd0); // R1
    AST_NULL_DATA_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        take && sel_zero && !is_stack |=> done && !fault_valid && seg_null); // R1
    AST_LIMIT_GP: assert property (@(posedge clk) disable iff (!rst_n)
        take && !sel_zero && (top_byte > tbl_lim) |=> done && fault_valid && fault_class == 2'd1 && !mem_rd_en); // R3
    AST_CODE_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> fault_code[1:0] == 2'b00); // R3
    AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> done); // R11
    AST_WB_SETS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> mem_wdata[8]); // R9
    AST_WB_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> done && !fault_valid && !mem_wr_en); // R9
    AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R2
endmodule

bind seg_load_checker seg_load_checker_chk #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_chk (.*);

// File: tb/sim_seg_load_checker.sv
// Bench: behavioural descriptor memory plus a per-load reference model,
// compared against the block on every cycle of each load.
`timescale 1ns/100ps
module sim_seg_load_checker;
    localparam int GDT_B = 32'h040;
    localparam int LDT_B = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_stack = 1'b0;
    logic [15:0] selector = '0;
    logic [1:0]  cpl = '0;
    logic [31:0] gdt_base = GDT_B;
    logic [15:0] gdt_limit = 16'h003F;
    logic [31:0] ldt_base = LDT_B;
    logic [15:0] ldt_limit = 16'h001F;
    logic        busy, done, fault_valid, seg_null;
    logic [1:0]  fault_class;
    logic [15:0] fault_code;
    logic [31:0] seg_base, seg_limit;
    logic [11:0] seg_attr;
    logic        mem_rd_en, mem_wr_en;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:127];
    int          wr_count = 0;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    seg_load_checker u0 (.*);

    // Memory with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[8:2]];
        if (mem_wr_en) begin
            mem[mem_addr[8:2]] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put_desc(input int word, input logic [31:0] b, input logic [19:0] lim,
                            input logic [3:0] typ, input bit s, input logic [1:0] dpl,
                            input bit p, input bit g);
        mem[word]     = {b[15:0], lim[15:0]};
        mem[word + 1] = {b[31:24], g, 1'b1, 2'b00, lim[19:16], p, dpl, s, typ, b[23:16]};
    endtask

    task automatic run_op(input bit stk, input logic [15:0] sel, input logic [1:0] c,
                          input string req);
        int          lat, fc, tb, tl, off, wi, r, w0;
        bit          fv, enul, wb;
        logic [31:0] lo, hi, eb, el, rawl;
        logic [11:0] ea;
        logic [1:0]  rpl, dpl;
        fv = 0; fc = 0; enul = 0; wb = 0; eb = 0; el = 0; ea = 0; wi = 0;
        rpl = sel[1:0];
        if (sel[15:2] == 0) begin
            lat = 1;
            if (stk) begin fv = 1; fc = 1; end else enul = 1;
        end else begin
            tb  = sel[2] ? LDT_B : GDT_B;
            tl  = sel[2] ? int'(ldt_limit) : int'(gdt_limit);
            off = int'(sel) & 16'hFFF8;
            if (off + 7 > tl) begin
                lat = 1; fv = 1; fc = 1;
            end else begin
                wi  = (tb + off) / 4;
                lo  = mem[wi];
                hi  = mem[wi + 1];
                dpl = hi[14:13];
                r   = 0;
                if (!hi[12]) r = 1;
                else if (stk) begin
                    if (hi[11] || !hi[9] || rpl != c || dpl != c) r = 1;
                end else begin
                    if (hi[11] && !hi[9]) r = 1;
                    else if (!(hi[11] && hi[10]) && (dpl < c || dpl < rpl)) r = 1;
                end
                if (r == 0 && !hi[15]) r = stk ? 2 : 3;
                fv  = (r != 0);
                fc  = r;
                wb  = !fv && !hi[8];
                lat = wb ? 5 : 4;
                eb  = {hi[31:24], hi[7:0], lo[31:16]};
                rawl = {12'd0, hi[19:16], lo[15:0]};
                el  = hi[23] ? ((rawl << 12) | 32'hFFF) : rawl;
                ea  = {hi[23:20], hi[15:9], 1'b1};
            end
        end
        w0 = wr_count;
        @(negedge clk);
        start = 1; is_stack = stk; selector = sel; cpl = c;
        @(negedge clk);
        start = 0;
        for (int k = 1; k <= 7; k++) begin
            if (k > 1) @(negedge clk);
            chk(done == (k == lat), req, $sformatf("done at cycle %0d", k), 32'(done), 32'(k == lat));
            if (k == lat) begin
                chk(fault_valid == fv, req, "fault_valid", 32'(fault_valid), 32'(fv));
                if (fv) begin
                    chk(fault_class == 2'(fc), req, "fault_class", 32'(fault_class), 32'(fc));
                    chk(fault_code == (sel & 16'hFFFC), req, "fault_code", 32'(fault_code), 32'(sel & 16'hFFFC));
                end else begin
                    chk(seg_null == enul, "R1", "seg_null", 32'(seg_null), 32'(enul));
                    chk(seg_base == eb, "R10", "base", seg_base, eb);
                    chk(seg_limit == el, "R10", "limit", seg_limit, el);
                    chk(seg_attr == ea, "R10", "attr", 32'(seg_attr), 32'(ea));
                end
            end
        end
        chk(wr_count - w0 == int'(wb), "R9", "write count", 32'(wr_count - w0), 32'(wb));
        if (wb) chk(mem[wi + 1][8] == 1'b1, "R9", "accessed bit stored", 32'(mem[wi + 1][8]), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        // Global table, index n at word 16 + 2n.
        put_desc(18, 32'h12345678, 20'hABCDE, 4'b0010, 1, 2'd3, 1, 0); // 1 RW data dpl3, A clear
        put_desc(20, 32'h00400000, 20'h00012, 4'b0001, 1, 2'd0, 1, 1); // 2 RO data dpl0, A set, 4K
        put_desc(22, 32'h00001000, 20'h0FFFF, 4'b1110, 1, 2'd0, 1, 0); // 3 conforming readable code
        put_desc(24, 32'h00002000, 20'h00FFF, 4'b1000, 1, 2'd3, 1, 0); // 4 exec-only code
        put_desc(26, 32'h00003000, 20'h00067, 4'b1001, 0, 2'd3, 1, 0); // 5 system descriptor
        put_desc(28, 32'h00004000, 20'h00100, 4'b0011, 1, 2'd2, 0, 0); // 6 not present data dpl2
        put_desc(30, 32'h00005000, 20'h00200, 4'b1011, 1, 2'd0, 1, 0); // 7 readable nonconforming code
        // Local table, index n at word 64 + 2n.
        put_desc(64, 32'hFEDC0000, 20'h00333, 4'b0011, 1, 2'd1, 1, 0); // 0 RW data dpl1, A set
        put_desc(70, 32'h0A0B0C0D, 20'hFFFFF, 4'b0010, 1, 2'd3, 1, 1); // 3 RW data dpl3, last entry
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!done && !busy && !fault_valid && !mem_rd_en && !mem_wr_en, "R11", "reset quiet",
            {27'd0, done, busy, fault_valid, mem_rd_en, mem_wr_en}, 32'd0);
        rst_n = 1;
        run_op(0, 16'h0003, 2'd3, "R1");  // null data
        run_op(1, 16'h0002, 2'd2, "R1");  // null stack
        run_op(0, 16'h000B, 2'd3, "R9");  // GDT1 write-back
        run_op(0, 16'h000B, 2'd3, "R9");  // GDT1 accessed already set
        run_op(1, 16'h000B, 2'd3, "R5");  // stack ok
        run_op(1, 16'h0008, 2'd0, "R5");  // stack dpl != cpl
        run_op(1, 16'h0010, 2'd0, "R5");  // stack read-only
        run_op(0, 16'h0010, 2'd0, "R10"); // granular limit
        run_op(0, 16'h0011, 2'd0, "R7");  // dpl < rpl
        run_op(0, 16'h001B, 2'd3, "R7");  // conforming exempt
        run_op(0, 16'h003B, 2'd3, "R7");  // nonconforming dpl < cpl
        run_op(0, 16'h0023, 2'd3, "R6");  // exec-only code
        run_op(1, 16'h0018, 2'd0, "R5");  // stack into code
        run_op(0, 16'h002B, 2'd3, "R4");  // system descriptor
        run_op(0, 16'h0030, 2'd0, "R8");  // not present data
        run_op(1, 16'h0032, 2'd2, "R8");  // not present stack
        run_op(0, 16'h001F, 2'd3, "R2");  // local table last entry
        run_op(0, 16'h0027, 2'd3, "R3");  // local over limit
        run_op(0, 16'h0040, 2'd0, "R3");  // global over limit
        run_op(1, 16'h0005, 2'd1, "R5");  // local stack ok
        run_op(1, 16'h0004, 2'd1, "R5");  // rpl != cpl
        run_op(0, 16'h0000, 2'd0, "R1");  // null again after activity
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule